// File: doc/BRIEF.md
# Endpoint Interrupt Summary Tree

This block gathers interrupt status from a set of IN endpoints and a set of OUT endpoints into a two-level summary that drives one interrupt line. Each endpoint owns a sticky status word. An event pulse sets a bit in that word. Software clears the bit by writing one to it. Each endpoint also has one bit in an all-endpoints summary word: IN endpoints occupy the low bits and OUT endpoints the bits above them. Two global bits, one for IN and one for OUT, summarise the all-endpoints word.

The summary levels hold no state of their own. They are computed at every moment from the endpoint status words and from the masks at each level. Clearing the endpoint bits that cause an interrupt is therefore the only way to lower the summary bits, the global bits and the interrupt line. Software first reads the global word, then the all-endpoints word to find the endpoint number, and then that endpoint's status word, which it clears.

The block has a simple single-cycle register port. Writes take effect at the clock edge, and reads return the selected word combinationally.

Top module: `ep_irq_tree`

## Requirements
- R1: An event pulse on bit b of an endpoint sets bit b of that endpoint's status word at the next clock edge. The bit stays set without further events. IN endpoint i is read at word address 8+i. OUT endpoint j is read at word address 8+N_IN+j, which is 12+j with the defaults.
- R2: Writing a word to an endpoint status address clears exactly the bits written as one. Bits written as zero are unchanged.
- R3: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit is set after the edge.
- R4: The all-endpoints word at address 2 has bit i equal to the OR of IN endpoint i's status ANDed with the IN event mask (address 4). Bit N_IN+j is the same reduction for OUT endpoint j using the OUT event mask (address 5). The endpoint mask does not affect this word.
- R5: The global word at address 0 has bit 0 equal to the OR of the IN bits of the all-endpoints word ANDed with the endpoint mask (address 3, same bit layout). Bit 1 is the same reduction for the OUT bits.
- R6: `irq` equals the OR of the global bits ANDed with the global mask (address 1: bit 0 for IN, bit 1 for OUT), delayed by one clock cycle.
- R7: Writes to the global word and to the all-endpoints word are ignored. Reads of these words always return the live derived value.
- R8: Clearing the endpoint status bits that cause a summary bit lowers that summary bit and the global bit in the same cycle that the status clears. The interrupt line falls one cycle later.
- R9: Reset clears every status word, every mask and `irq`.
- R10: The four mask words are read/write and read back the value last written, limited to their width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ev | input | N_IN*EVW | Event pulses for the IN endpoints; endpoint i uses bits [i*EVW +: EVW] |
| out_ev | input | N_OUT*EVW | Event pulses for the OUT endpoints, packed the same way |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware event setting a status bit, and a software write-one-to-clear of that same bit. The bench drives an event pulse and a clear write to the same endpoint bit on one clock edge, then reads the status word back. The bit must still read as one. The bench also checks the interrupt latency around a clear: after the write, the summary drops at once, `irq` stays high for exactly one more sampled cycle, and then falls.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

   // fixed word offsets of the summary and mask registers
   localparam int unsigned A_GSTAT  = 0;
   localparam int unsigned A_GMASK  = 1;
   localparam int unsigned A_AEP    = 2;
   localparam int unsigned A_AEPMSK = 3;
   localparam int unsigned A_INEVM  = 4;
   localparam int unsigned A_OUTEVM = 5;
   localparam int unsigned A_EPBASE = 8;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GSTAT,
      SEL_GMASK,
      SEL_AEP,
      SEL_AEPMSK,
      SEL_INEVM,
      SEL_OUTEVM,
      SEL_EP
   } reg_sel_e;

endpackage

// File: rtl/ep_stat_reg.sv
module ep_stat_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat
);

   // an event on the same edge as a clear takes priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr) | ev;
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_chk
         a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ev[b] |=> stat[b]);
         a_r2_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[b] && !ev[b]) |=> !stat[b]);
         a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[b] && !clr[b]) |=> stat[b]);
      end
   endgenerate

endmodule

// File: rtl/ep_bank.sv
module ep_bank #(
   parameter int unsigned N   = 4,
   parameter int unsigned EVW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N*EVW-1:0]      ev,
   input  logic [N*EVW-1:0]      clr,
   input  logic [EVW-1:0]        evmask,
   output logic [N*EVW-1:0]      stat,
   output logic [N-1:0]          hit
);

   localparam int unsigned TOTAL = N * EVW;

   generate
      if (N < 1) begin : g_bad_n
         $error("ep_bank: N must be at least 1");
      end
      if (TOTAL > 4096) begin : g_bad_size
         $error("ep_bank: too many status bits");
      end

      for (genvar i = 0; i < N; i++) begin : g_ep
         ep_stat_reg #(.W(EVW)) u_stat (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev[i*EVW +: EVW]),
            .clr   (clr[i*EVW +: EVW]),
            .stat  (stat[i*EVW +: EVW])
         );
         assign hit[i] = |(stat[i*EVW +: EVW] & evmask);
      end
   endgenerate

endmodule

// File: rtl/ep_irq_tree.sv
module ep_irq_tree
   import ep_irq_pkg::*;
#(
   parameter int unsigned N_IN    = 4,
   parameter int unsigned N_OUT   = 4,
   parameter int unsigned EVW     = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned ADDR_W  = 5,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN*EVW-1:0]    in_ev,
   input  logic [N_OUT*EVW-1:0]   out_ev,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DW-1:0]          wdata,
   output logic [DW-1:0]          rdata,
   output logic                   irq
);

   localparam int unsigned NEP      = N_IN + N_OUT;
   localparam int unsigned OUT_BASE = A_EPBASE + N_IN;
   localparam int unsigned END_ADDR = OUT_BASE + N_OUT;

   generate
      if (NEP > DW) begin : g_bad_dw
         $error("ep_irq_tree: endpoint count exceeds data width");
      end
      if (EVW > DW) begin : g_bad_evw
         $error("ep_irq_tree: event width exceeds data width");
      end
      if (END_ADDR > (1 << ADDR_W)) begin : g_bad_addr
         $error("ep_irq_tree: address width too small");
      end
   endgenerate

   // ---------------- mask registers ----------------
   logic [1:0]     gmask;
   logic [NEP-1:0] aepmask;
   logic [EVW-1:0] in_evm, out_evm;
   reg_sel_e       sel;

   always_comb begin
      sel = SEL_NONE;
      if      (addr == ADDR_W'(A_GSTAT))  sel = SEL_GSTAT;
      else if (addr == ADDR_W'(A_GMASK))  sel = SEL_GMASK;
      else if (addr == ADDR_W'(A_AEP))    sel = SEL_AEP;
      else if (addr == ADDR_W'(A_AEPMSK)) sel = SEL_AEPMSK;
      else if (addr == ADDR_W'(A_INEVM))  sel = SEL_INEVM;
      else if (addr == ADDR_W'(A_OUTEVM)) sel = SEL_OUTEVM;
      else if (addr >= ADDR_W'(A_EPBASE) && addr < ADDR_W'(END_ADDR)) sel = SEL_EP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gmask   <= '0;
         aepmask <= '0;
         in_evm  <= '0;
         out_evm <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_GMASK:  gmask   <= wdata[1:0];
            SEL_AEPMSK: aepmask <= wdata[NEP-1:0];
            SEL_INEVM:  in_evm  <= wdata[EVW-1:0];
            SEL_OUTEVM: out_evm <= wdata[EVW-1:0];
            default: ;
         endcase
      end
   end

   // ---------------- endpoint banks ----------------
   logic [N_IN*EVW-1:0]  in_clr, in_stat;
   logic [N_OUT*EVW-1:0] out_clr, out_stat;
   logic [N_IN-1:0]      in_hit;
   logic [N_OUT-1:0]     out_hit;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_in_clr
         assign in_clr[i*EVW +: EVW] =
            (wr_en && addr == ADDR_W'(A_EPBASE + i)) ? wdata[EVW-1:0] : '0;
      end
      for (genvar j = 0; j < N_OUT; j++) begin : g_out_clr
         assign out_clr[j*EVW +: EVW] =
            (wr_en && addr == ADDR_W'(OUT_BASE + j)) ? wdata[EVW-1:0] : '0;
      end
   endgenerate

   ep_bank #(.N(N_IN), .EVW(EVW)) u_in_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (in_ev),
      .clr    (in_clr),
      .evmask (in_evm),
      .stat   (in_stat),
      .hit    (in_hit)
   );

   ep_bank #(.N(N_OUT), .EVW(EVW)) u_out_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (out_ev),
      .clr    (out_clr),
      .evmask (out_evm),
      .stat   (out_stat),
      .hit    (out_hit)
   );

   // ---------------- derived summary levels ----------------
   logic [NEP-1:0] aep;
   logic [1:0]     glob;
   logic           irq_d;

   assign aep     = {out_hit, in_hit};
   assign glob[0] = |(in_hit  & aepmask[N_IN-1:0]);
   assign glob[1] = |(out_hit & aepmask[NEP-1:N_IN]);
   assign irq_d   = |(glob & gmask);

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_d;
         end
         assign irq = irq_q;

         a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
            irq_d |=> irq);
         a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_d |=> !irq);
      end else begin : g_irq_comb
         assign irq = irq_d;
      end
   endgenerate

   // ---------------- read mux ----------------
   always_comb begin
      rdata = '0;
      case (sel)
         SEL_GSTAT:  rdata = DW'(glob);
         SEL_GMASK:  rdata = DW'(gmask);
         SEL_AEP:    rdata = DW'(aep);
         SEL_AEPMSK: rdata = DW'(aepmask);
         SEL_INEVM:  rdata = DW'(in_evm);
         SEL_OUTEVM: rdata = DW'(out_evm);
         SEL_EP: begin
            for (int i = 0; i < int'(N_IN); i++)
               if (addr == ADDR_W'(A_EPBASE + i)) rdata = DW'(in_stat[i*EVW +: EVW]);
            for (int j = 0; j < int'(N_OUT); j++)
               if (addr == ADDR_W'(OUT_BASE + j)) rdata = DW'(out_stat[j*EVW +: EVW]);
         end
         default: rdata = '0;
      endcase
   end

   // R7: summary words are not writable, masks stay put
   a_r7_summary_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (sel == SEL_GSTAT || sel == SEL_AEP))
      |=> ($stable(gmask) && $stable(aepmask) && $stable(in_evm) && $stable(out_evm)));

   // R8: no global bit without a pending summary bit
   a_r8_glob_needs_aep: assert property (@(posedge clk) disable iff (!rst_n)
      glob[0] |-> (|in_hit));

endmodule

// File: tb/ep_irq_tree_tb_top.sv
module ep_irq_tree_tb_top;

   localparam int N_IN = 4, N_OUT = 4, EVW = 8, DW = 32, AW = 5;
   localparam int NV = 52;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_IN*EVW-1:0]  in_ev = '0;
   logic [N_OUT*EVW-1:0] out_ev = '0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [DW-1:0]     wdata = '0;
   logic [DW-1:0]     rdata;
   logic              irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;   // 250 MHz

   ep_irq_tree #(.N_IN(N_IN), .N_OUT(N_OUT), .EVW(EVW), .DW(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_ev(in_ev), .out_ev(out_ev),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   // op: 0 write, 1 read-check, 2 IN event (addr = endpoint), 3 OUT event
   // fields: {op[1:0], addr[7:0], data[31:0], expected[31:0], req[7:0]}
   localparam logic [81:0] VEC [NV] = '{
      {2'd1, 8'd0,  32'h0,  32'h0,  8'd9},   // R9 global clear
      {2'd1, 8'd2,  32'h0,  32'h0,  8'd9},
      {2'd1, 8'd1,  32'h0,  32'h0,  8'd9},
      {2'd1, 8'd9,  32'h0,  32'h0,  8'd9},
      {2'd0, 8'd4,  32'hff, 32'h0,  8'd10},  // R10 masks
      {2'd0, 8'd5,  32'hff, 32'h0,  8'd10},
      {2'd0, 8'd3,  32'hfff,32'h0,  8'd10},
      {2'd0, 8'd1,  32'h7,  32'h0,  8'd10},
      {2'd1, 8'd1,  32'h0,  32'h3,  8'd10},
      {2'd1, 8'd3,  32'h0,  32'hff, 8'd10},
      {2'd1, 8'd4,  32'h0,  32'hff, 8'd10},
      {2'd2, 8'd1,  32'h05, 32'h0,  8'd1},   // R1 event IN ep1
      {2'd1, 8'd9,  32'h0,  32'h05, 8'd1},
      {2'd1, 8'd2,  32'h0,  32'h02, 8'd4},
      {2'd1, 8'd0,  32'h0,  32'h1,  8'd5},
      {2'd3, 8'd2,  32'h80, 32'h0,  8'd1},   // R1 event OUT ep2
      {2'd1, 8'd14, 32'h0,  32'h80, 8'd1},
      {2'd1, 8'd2,  32'h0,  32'h42, 8'd4},
      {2'd1, 8'd0,  32'h0,  32'h3,  8'd5},
      {2'd2, 8'd1,  32'h02, 32'h0,  8'd1},
      {2'd1, 8'd9,  32'h0,  32'h07, 8'd1},
      {2'd0, 8'd9,  32'h04, 32'h0,  8'd2},   // R2 W1C
      {2'd1, 8'd9,  32'h0,  32'h03, 8'd2},
      {2'd0, 8'd9,  32'h00, 32'h0,  8'd2},
      {2'd1, 8'd9,  32'h0,  32'h03, 8'd2},
      {2'd0, 8'd2,  32'hff, 32'h0,  8'd7},   // R7 read-only summaries
      {2'd1, 8'd2,  32'h0,  32'h42, 8'd7},
      {2'd0, 8'd0,  32'h0,  32'h0,  8'd7},
      {2'd1, 8'd0,  32'h0,  32'h3,  8'd7},
      {2'd1, 8'd1,  32'h0,  32'h3,  8'd7},
      {2'd0, 8'd4,  32'h04, 32'h0,  8'd4},   // R4 event mask
      {2'd1, 8'd2,  32'h0,  32'h40, 8'd4},
      {2'd1, 8'd0,  32'h0,  32'h2,  8'd5},
      {2'd0, 8'd3,  32'h0f, 32'h0,  8'd5},   // R5 endpoint mask
      {2'd1, 8'd0,  32'h0,  32'h0,  8'd5},
      {2'd1, 8'd2,  32'h0,  32'h40, 8'd4},
      {2'd1, 8'd14, 32'h0,  32'h80, 8'd5},
      {2'd0, 8'd14, 32'h80, 32'h0,  8'd8},   // R8 clear propagates
      {2'd1, 8'd2,  32'h0,  32'h00, 8'd8},
      {2'd1, 8'd0,  32'h0,  32'h0,  8'd8},
      {2'd0, 8'd4,  32'hff, 32'h0,  8'd8},
      {2'd1, 8'd2,  32'h0,  32'h02, 8'd8},
      {2'd1, 8'd0,  32'h0,  32'h1,  8'd8},
      {2'd0, 8'd9,  32'h03, 32'h0,  8'd8},
      {2'd1, 8'd2,  32'h0,  32'h00, 8'd8},
      {2'd1, 8'd0,  32'h0,  32'h0,  8'd8},
      {2'd1, 8'd9,  32'h0,  32'h0,  8'd8},
      {2'd3, 8'd3,  32'h11, 32'h0,  8'd4},
      {2'd1, 8'd15, 32'h0,  32'h11, 8'd1},
      {2'd1, 8'd2,  32'h0,  32'h80, 8'd4},
      {2'd0, 8'd15, 32'h11, 32'h0,  8'd2},
      {2'd1, 8'd15, 32'h0,  32'h00, 8'd2}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input int a, input logic [31:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input int a, input logic [31:0] exp, input int req);
      @(negedge clk);
      addr = AW'(a);
      #1;
      check(rdata, exp, req);
   endtask

   task automatic pulse(input bit is_out, input int ep, input logic [7:0] bits);
      @(negedge clk);
      if (is_out) out_ev[ep*EVW +: EVW] = bits;
      else        in_ev[ep*EVW +: EVW] = bits;
      @(negedge clk);
      in_ev = '0; out_ev = '0;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual %0d expected below 100000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check({31'b0, irq}, 32'h0, 9);   // R9 irq low after reset
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         case (VEC[k][81:80])
            2'd0: do_write(int'(VEC[k][79:72]), VEC[k][71:40]);
            2'd1: do_read(int'(VEC[k][79:72]), VEC[k][39:8], int'(VEC[k][7:0]));
            2'd2: pulse(1'b0, int'(VEC[k][79:72]), VEC[k][47:40]);
            default: pulse(1'b1, int'(VEC[k][79:72]), VEC[k][47:40]);
         endcase
      end

      // R6: irq one cycle after the global bit (masks: in ff, ep 0f, g 3)
      @(negedge clk);
      in_ev[7:0] = 8'h01;
      @(negedge clk);
      in_ev = '0;
      #1 check({31'b0, irq}, 32'h0, 6);
      @(negedge clk);
      #1 check({31'b0, irq}, 32'h1, 6);

      // R8: clear drops summary now, irq a cycle later
      @(negedge clk);
      addr = AW'(8); wdata = 32'h1; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; addr = AW'(0);
      #1 check(rdata, 32'h0, 8);
      check({31'b0, irq}, 32'h1, 8);
      @(negedge clk);
      #1 check({31'b0, irq}, 32'h0, 8);

      // R3: event and clear on the same bit in one cycle
      @(negedge clk);
      in_ev[7:0] = 8'h01; addr = AW'(8); wdata = 32'h1; wr_en = 1'b1;
      @(negedge clk);
      in_ev = '0; wr_en = 1'b0;
      #1 check(rdata, 32'h1, 3);

      // R6: global mask gates irq
      do_write(1, 32'h2);
      repeat (2) @(negedge clk);
      #1 check({31'b0, irq}, 32'h0, 6);
      do_read(0, 32'h1, 5);
      do_write(1, 32'h1);
      @(negedge clk);
      #1 check({31'b0, irq}, 32'h1, 6);

      // R9: reset mid-run clears pending state
      @(negedge clk);
      rst_n = 1'b0;
      #1 check({31'b0, irq}, 32'h0, 9);
      addr = AW'(8);
      #1 check(rdata, 32'h0, 9);
      addr = AW'(1);
      #1 check(rdata, 32'h0, 9);
      @(negedge clk);
      rst_n = 1'b1;
      do_read(3, 32'h0, 9);

      finish_run();
   end

endmodule